// File: doc/BRIEF.md
# Interrupt Source State Controller

This block keeps the state of a small, fixed table of interrupt sources and turns their activity into interrupt offers for a downstream presentation unit. Each table entry is built either as a level source or as a message (edge) source. The choice is made by a parameter bit per entry. Each entry holds a destination server number, a priority and its status flags. A priority of all ones masks the entry.

Sources raise events through per-entry input lines. Software programs server and priority through a configuration write port. The presentation unit answers offers with reject and end-of-interrupt (EOI) commands that carry external source numbers, and it can ask for a resend. A resend walks the whole table one entry per cycle and replays work that was held back. Offers leave the block one at a time over a valid/ready handshake as a (server, source number, priority) triple.

Top module: `irq_src_ctrl`

## Requirements
- R1: After reset no offer is pending, every entry is masked (priority all ones) and all status flags are clear. A message trigger that arrives right after reset produces no offer.
- R2: A message entry triggers on a rising edge of its line. If the entry is masked, the event is held as masked-pending. Otherwise an offer is made.
- R3: A level entry's asserted flag follows its line. When the line changes, the entry is offered if it is unmasked, asserted and not already sent, and it is then marked sent. A line held high produces no second offer.
- R4: A reject sets the rejected flag of a message entry and clears the sent flag of a level entry. Neither causes an immediate re-offer.
- R5: A configuration write replaces server and priority. A masked-pending message entry that is now unmasked is offered and its pending flag is cleared. A level entry runs its offer check.
- R6: A resend scans every entry in index order, one per cycle. A rejected message entry has the flag cleared and is re-offered if unmasked. A level entry runs its offer check. A second resend with nothing held produces no offer.
- R7: An EOI clears the sent flag of a level entry without offering it. An EOI to a message entry has no effect.
- R8: Reset does not change whether an entry is a level or a message entry. Bit i of LVL_MASK set to 1 makes entry i a level entry.
- R9: External source number = BASE + index. Reject and EOI numbers below BASE or at or above BASE + NUM_SRC are ignored, even when their low bits match a real index.
- R10: Only one offer is outstanding at a time. It stays stable until it is accepted with off_ready, and among simultaneous requests the lowest index goes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | NUM_SRC | Per-entry source line |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Entry index for the write |
| cfg_server | input | SRV_W | New destination server |
| cfg_prio | input | PRIO_W | New priority (all ones masks) |
| rej_valid | input | 1 | Reject command strobe |
| rej_num | input | NUM_W | External number being rejected |
| eoi_valid | input | 1 | EOI command strobe |
| eoi_num | input | NUM_W | External number being completed |
| resend_req | input | 1 | Starts (or restarts) a table scan |
| off_valid | output | 1 | Offer present |
| off_ready | input | 1 | Offer accepted this cycle |
| off_server | output | SRV_W | Offer destination server |
| off_num | output | NUM_W | Offer external source number |
| off_prio | output | PRIO_W | Offer priority |

## Verification
Message entries are driven with single pulses while masked, while unmasked, and after a reject. These runs separate the masked-pending path from the immediate offer and from replay on resend. Level entries are held high across offers, EOIs and rejects. These runs show that a level line alone never re-offers, and that the sent flag is cleared only by reject or EOI and is acted on only by a resend, a line change or a configuration write. Out-of-range numbers whose low bits alias a live entry show that decoding checks the full range. A simultaneous two-entry trigger with a stalled consumer shows ordering and hold behaviour.

// File: rtl/irq_src_pkg.sv
// Shared definitions for the interrupt source state controller.
// Assumes: priorities are unsigned; the all-ones value means masked.
package irq_src_pkg;
    typedef enum logic {
        KIND_MSG = 1'b0,
        KIND_LVL = 1'b1
    } src_kind_e;
endpackage

// File: rtl/irq_num_decode.sv
// Converts an external source number into a one-hot entry hit.
// Assumes: numbers outside [BASE, BASE+NUM_SRC) must produce no hit.
module irq_num_decode #(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned NUM_W   = 12,
    parameter int unsigned BASE    = 256
) (
    input  logic               valid,
    input  logic [NUM_W-1:0]   num,
    output logic [NUM_SRC-1:0] hit
);
    logic [NUM_W-1:0] diff;
    logic             in_range;

    // Range test on the full number, then one-hot compare of the offset.
    always_comb begin
        diff     = num - NUM_W'(BASE);
        in_range = (num >= NUM_W'(BASE)) && (diff < NUM_W'(NUM_SRC));
        for (int i = 0; i < NUM_SRC; i++)
            hit[i] = valid && in_range && (diff == NUM_W'(i));
    end
endmodule

// File: rtl/irq_src_entry.sv
// One table entry: configuration and the status flags of one source.
// The entry kind (level or message) is fixed by a parameter, so reset
// cannot change it. req asks the arbiter for an offer; grant retires it.
// Assumes: grant is only given while req is high.
module irq_src_entry
    import irq_src_pkg::*;
#(
    parameter src_kind_e   KIND   = KIND_MSG,
    parameter int unsigned SRV_W  = 4,
    parameter int unsigned PRIO_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_in,
    input  logic              cfg_hit,
    input  logic [SRV_W-1:0]  cfg_server,
    input  logic [PRIO_W-1:0] cfg_prio,
    input  logic              rej_hit,
    input  logic              eoi_hit,
    input  logic              scan_hit,
    input  logic              grant,
    output logic              req,
    output logic [SRV_W-1:0]  server,
    output logic [PRIO_W-1:0] prio
);
    localparam logic [PRIO_W-1:0] MASKED = '1;

    logic [SRV_W-1:0]  srv_q, srv_n;
    logic [PRIO_W-1:0] prio_q, prio_n;
    logic line_q, sent_q, rejd_q, mpend_q, req_q;
    logic sent_n, rejd_n, mpend_n, req_n, unmasked;

    // Apply reject, EOI, config, line and scan events in one cycle.
    always_comb begin
        srv_n   = srv_q;
        prio_n  = prio_q;
        sent_n  = sent_q;
        rejd_n  = rejd_q;
        mpend_n = mpend_q;
        req_n   = req_q && !grant;
        if (cfg_hit) begin
            srv_n  = cfg_server;
            prio_n = cfg_prio;
        end
        unmasked = (prio_n != MASKED);
        if (KIND == KIND_LVL) begin
            if (rej_hit || eoi_hit) sent_n = 1'b0;
            if (!unmasked && req_n) begin
                req_n  = 1'b0;
                sent_n = 1'b0;
            end
            if (((line_in != line_q) || cfg_hit || scan_hit) &&
                unmasked && line_in && !sent_n) begin
                sent_n = 1'b1;
                req_n  = 1'b1;
            end
        end else begin
            if (rej_hit) rejd_n = 1'b1;
            if (line_in && !line_q) begin
                if (unmasked) req_n = 1'b1;
                else          mpend_n = 1'b1;
            end
            if (cfg_hit && mpend_n && unmasked) begin
                mpend_n = 1'b0;
                req_n   = 1'b1;
            end
            if (scan_hit && rejd_n) begin
                rejd_n = 1'b0;
                if (unmasked) req_n = 1'b1;
            end
            if (!unmasked && req_n) begin
                req_n   = 1'b0;
                mpend_n = 1'b1;
            end
        end
    end

    // State registers; reset masks the entry and clears every flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srv_q   <= '0;
            prio_q  <= MASKED;
            line_q  <= 1'b0;
            sent_q  <= 1'b0;
            rejd_q  <= 1'b0;
            mpend_q <= 1'b0;
            req_q   <= 1'b0;
        end else begin
            srv_q   <= srv_n;
            prio_q  <= prio_n;
            line_q  <= line_in;
            sent_q  <= sent_n;
            rejd_q  <= rejd_n;
            mpend_q <= mpend_n;
            req_q   <= req_n;
        end
    end

    assign req    = req_q;
    assign server = srv_q;
    assign prio   = prio_q;
endmodule

// File: rtl/irq_src_ctrl.sv
// Interrupt source state controller: a table of NUM_SRC entries, a
// lowest-index arbiter feeding a single offer register, and a resend
// scanner that visits one entry per cycle and stalls while an offer waits.
// Assumes: LVL_MASK bit i set makes entry i a level source.
module irq_src_ctrl
    import irq_src_pkg::*;
#(
    parameter int unsigned          NUM_SRC  = 8,
    parameter int unsigned          SRV_W    = 4,
    parameter int unsigned          PRIO_W   = 8,
    parameter int unsigned          NUM_W    = 12,
    parameter int unsigned          BASE     = 256,
    parameter logic [NUM_SRC-1:0]   LVL_MASK = 8'hF0,
    localparam int unsigned         IDX_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [SRV_W-1:0]   cfg_server,
    input  logic [PRIO_W-1:0]  cfg_prio,
    input  logic               rej_valid,
    input  logic [NUM_W-1:0]   rej_num,
    input  logic               eoi_valid,
    input  logic [NUM_W-1:0]   eoi_num,
    input  logic               resend_req,
    output logic               off_valid,
    input  logic               off_ready,
    output logic [SRV_W-1:0]   off_server,
    output logic [NUM_W-1:0]   off_num,
    output logic [PRIO_W-1:0]  off_prio
);
    logic [NUM_SRC-1:0] rej_hit, eoi_hit, scan_hit, cfg_hit, req, grant;
    logic [SRV_W-1:0]   srv_a  [NUM_SRC];
    logic [PRIO_W-1:0]  prio_a [NUM_SRC];
    logic [IDX_W-1:0]   pick, scan_ptr;
    logic               found, scan_on;

    irq_num_decode #(.NUM_SRC(NUM_SRC), .NUM_W(NUM_W), .BASE(BASE)) u_rej_dec (
        .valid(rej_valid), .num(rej_num), .hit(rej_hit));
    irq_num_decode #(.NUM_SRC(NUM_SRC), .NUM_W(NUM_W), .BASE(BASE)) u_eoi_dec (
        .valid(eoi_valid), .num(eoi_num), .hit(eoi_hit));

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_ent
        localparam src_kind_e KIND = LVL_MASK[g] ? KIND_LVL : KIND_MSG;
        assign cfg_hit[g]  = cfg_we && (cfg_idx == IDX_W'(g));
        assign scan_hit[g] = scan_on && !off_valid && (scan_ptr == IDX_W'(g));
        irq_src_entry #(.KIND(KIND), .SRV_W(SRV_W), .PRIO_W(PRIO_W)) u_ent (
            .clk(clk), .rst_n(rst_n), .line_in(src_in[g]),
            .cfg_hit(cfg_hit[g]), .cfg_server(cfg_server), .cfg_prio(cfg_prio),
            .rej_hit(rej_hit[g]), .eoi_hit(eoi_hit[g]), .scan_hit(scan_hit[g]),
            .grant(grant[g]), .req(req[g]), .server(srv_a[g]), .prio(prio_a[g]));
    end

    // Lowest-index request wins; grant only when the offer slot is empty.
    always_comb begin
        found = 1'b0;
        pick  = '0;
        grant = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (!found && req[i]) begin
                found    = 1'b1;
                pick     = IDX_W'(i);
                grant[i] = !off_valid;
            end
        end
    end

    // Offer register: load a granted entry, clear on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_valid  <= 1'b0;
            off_server <= '0;
            off_num    <= '0;
            off_prio   <= '0;
        end else if (off_valid) begin
            if (off_ready) off_valid <= 1'b0;
        end else if (found) begin
            off_valid  <= 1'b1;
            off_server <= srv_a[pick];
            off_prio   <= prio_a[pick];
            off_num    <= NUM_W'(BASE) + NUM_W'(pick);
        end
    end

    // Resend scanner: one entry per free cycle, restart on a new request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scan_on  <= 1'b0;
            scan_ptr <= '0;
        end else if (resend_req) begin
            scan_on  <= 1'b1;
            scan_ptr <= '0;
        end else if (scan_on && !off_valid) begin
            if (scan_ptr == IDX_W'(NUM_SRC - 1)) begin
                scan_on  <= 1'b0;
                scan_ptr <= '0;
            end else begin
                scan_ptr <= scan_ptr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_src_ctrl_chk.sv
// Property checker for the offer interface of irq_src_ctrl.
// Assumes: bound to every instance of the top module.
module irq_src_ctrl_chk #(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned SRV_W   = 4,
    parameter int unsigned PRIO_W  = 8,
    parameter int unsigned NUM_W   = 12,
    parameter int unsigned BASE    = 256
) (
    input logic              clk,
    input logic              rst_n,
    input logic              off_valid,
    input logic              off_ready,
    input logic [SRV_W-1:0]  off_server,
    input logic [NUM_W-1:0]  off_num,
    input logic [PRIO_W-1:0] off_prio
);
    // R1: reset leaves no offer pending
    p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !off_valid);

    // R10: an unaccepted offer stays put
    p_offer_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        off_valid && !off_ready |=> off_valid && $stable(off_num)
                                    && $stable(off_prio) && $stable(off_server));

    // R2: a masked priority is never offered
    p_no_masked_offer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        off_valid |-> off_prio != '1);

    // R9: offered numbers lie in the table range
    p_num_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        off_valid |-> (off_num >= NUM_W'(BASE)) && (off_num < NUM_W'(BASE + NUM_SRC)));
endmodule

bind irq_src_ctrl irq_src_ctrl_chk #(
    .NUM_SRC(NUM_SRC), .SRV_W(SRV_W), .PRIO_W(PRIO_W), .NUM_W(NUM_W), .BASE(BASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .off_valid(off_valid), .off_ready(off_ready),
    .off_server(off_server), .off_num(off_num), .off_prio(off_prio)
);

// File: tb/irq_src_ctrl_test.sv
// Directed bench: entries 0-3 message, 4-7 level, BASE 0x100.
module irq_src_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [N-1:0] src_in = '0;
    logic cfg_we = 0, rej_valid = 0, eoi_valid = 0, resend_req = 0, off_ready = 0;
    logic [2:0]  cfg_idx = '0;
    logic [3:0]  cfg_server = '0;
    logic [7:0]  cfg_prio = '0;
    logic [11:0] rej_num = '0, eoi_num = '0;
    logic        off_valid;
    logic [3:0]  off_server;
    logic [11:0] off_num;
    logic [7:0]  off_prio;
    int total = 0, bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_src_ctrl uut (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_server(cfg_server), .cfg_prio(cfg_prio), .rej_valid(rej_valid),
        .rej_num(rej_num), .eoi_valid(eoi_valid), .eoi_num(eoi_num),
        .resend_req(resend_req), .off_valid(off_valid), .off_ready(off_ready),
        .off_server(off_server), .off_num(off_num), .off_prio(off_prio));

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg(input int idx, input int srv, input int pr);
        @(negedge clk);
        cfg_we = 1; cfg_idx = 3'(idx); cfg_server = 4'(srv); cfg_prio = 8'(pr);
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic pulse_src(input int idx);
        @(negedge clk); src_in[idx] = 1'b1;
        @(negedge clk); src_in[idx] = 1'b0;
    endtask

    task automatic reject(input int num);
        @(negedge clk); rej_valid = 1; rej_num = 12'(num);
        @(negedge clk); rej_valid = 0;
    endtask

    task automatic eoi(input int num);
        @(negedge clk); eoi_valid = 1; eoi_num = 12'(num);
        @(negedge clk); eoi_valid = 0;
    endtask

    task automatic resend();
        @(negedge clk); resend_req = 1;
        @(negedge clk); resend_req = 0;
    endtask

    // Wait for an offer, check its fields, then accept it.
    task automatic expect_offer(string tag, int num, int pr, int srv);
        for (int k = 0; k < 40 && !off_valid; k++) @(negedge clk);
        check({tag, " offer valid"}, off_valid, 1);
        check({tag, " num"}, off_num, num);
        check({tag, " prio"}, off_prio, pr);
        check({tag, " server"}, off_server, srv);
        off_ready = 1;
        @(negedge clk);
        off_ready = 0;
    endtask

    // No offer may appear for a number of cycles.
    task automatic expect_none(string tag, int cycles);
        logic seen = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (off_valid) seen = 1;
        end
        check({tag, " no offer"}, seen, 0);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R1 idle after reset", off_valid, 0);
        pulse_src(0);
        expect_none("R1 masked after reset", 6);
    endtask

    task automatic t_msg_paths();
        cfg(0, 3, 5);
        expect_offer("R5 masked-pending released", 'h100, 5, 3);
        pulse_src(0);
        expect_offer("R2 immediate message offer", 'h100, 5, 3);
    endtask

    task automatic t_msg_reject();
        cfg(1, 2, 9);
        pulse_src(1);
        expect_offer("R2 src1", 'h101, 9, 2);
        reject('h101);
        expect_none("R4 message reject holds", 5);
        resend();
        expect_offer("R6 replay rejected message", 'h101, 9, 2);
        resend();
        expect_none("R6 second resend empty", 14);
        eoi('h101);
        resend();
        expect_none("R7 message EOI no effect", 14);
    endtask

    task automatic t_level();
        cfg(4, 1, 2);
        expect_none("R3 low line no offer", 3);
        @(negedge clk); src_in[4] = 1;
        expect_offer("R3 level assert", 'h104, 2, 1);
        expect_none("R3 held line sent once", 6);
        eoi('h104);
        expect_none("R7 level EOI no immediate offer", 5);
        resend();
        expect_offer("R7 level re-offer after EOI", 'h104, 2, 1);
        reject('h104);
        expect_none("R4 level reject holds", 5);
        resend();
        expect_offer("R4 level replay after reject", 'h104, 2, 1);
        @(negedge clk); src_in[4] = 0;
        expect_none("R3 falling line", 3);
    endtask

    task automatic t_range();
        @(negedge clk); src_in[5] = 1;
        expect_none("R3 masked level", 3);
        cfg(5, 6, 7);
        expect_offer("R5 level config check", 'h105, 7, 6);
        reject('h10D);
        resend();
        expect_none("R9 reject above range", 14);
        reject('h0FD);
        eoi('h10D);
        resend();
        expect_none("R9 reject/EOI below or above range", 14);
        eoi('h105);
        resend();
        expect_offer("R9 in-range EOI", 'h105, 7, 6);
        @(negedge clk); src_in[5] = 0;
    endtask

    task automatic t_arbitration();
        cfg(2, 4, 4);
        cfg(3, 5, 3);
        @(negedge clk); src_in[2] = 1; src_in[3] = 1;
        @(negedge clk); src_in[2] = 0; src_in[3] = 0;
        repeat (5) @(negedge clk);
        check("R10 lowest index first", off_num, 'h102);
        check("R10 held while not ready", off_valid, 1);
        expect_offer("R10 first", 'h102, 4, 4);
        expect_offer("R10 second", 'h103, 3, 5);
    endtask

    task automatic t_reset_keeps_kind();
        @(negedge clk); src_in[4] = 1;
        do_reset();
        check("R1 reset clears offer", off_valid, 0);
        expect_none("R8 level masked after reset", 4);
        pulse_src(1);
        expect_none("R8 message masked after reset", 4);
        cfg(4, 0, 3);
        expect_offer("R8 level kind kept", 'h104, 3, 0);
        @(negedge clk); src_in[4] = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog R10 actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset_state();
        t_msg_paths();
        t_msg_reject();
        t_level();
        t_range();
        t_arbitration();
        t_reset_keeps_kind();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule